// File: doc/BRIEF.md
# Error and Mode Status Register with Set/Clear Command Word

This block keeps the state word of a serial port controller: an enable bit that selects between configuration mode and run mode, a master-select bit, five sticky error flags (transmit overflow, receive overflow, abort, transmit underflow, receive underflow) and a mode-error flag. Software never writes the state word as a value. It writes a 16-bit command word in which every flag has its own set bit and its own clear bit, so one flag can be changed without a read-modify-write of the others.

Hardware event inputs from the shift engine set the error flags. Each of the five events only reaches its flag when the matching error-enable bit is high. A separate 4-bit interrupt-enable register holds the receive, transmit, error and frame-end request enables. The block drives one error interrupt line from the enabled flags, masked by the error request enable. The busy input from the shift engine is shown in the state word. Bus address decoding stays outside the block.

Top module: `err_status_reg`

## Requirements
- R1: After reset, all flags, the error enables and the interrupt enables are 0, `status_o` is 0x0000 (busy low), `err_irq_o` is 0 and `cfg_mode_o` is 1.
- R2: A command write with bit 1 set (bit 0 clear) sets the enable flag (`status_o[0]`), and bit 0 alone clears it. Bit 3 alone sets the master flag (`status_o[1]`), and bit 2 alone clears it. The change shows one cycle after the write.
- R3: For the error flags, the command clear bits are transmit overflow 8, receive overflow 9, abort 10, transmit underflow 11 and receive underflow 4. The set bits are 12, 13, 14, 15 and 5. The flags show in `status_o` at bits 8, 9, 10, 11 and 12.
- R4: When a set bit and its matching clear bit are written together, the flag keeps its value.
- R5: Writing 0x0F50 clears all five error flags and the mode-error flag, and leaves the enable and master flags unchanged.
- R6: `err_ev_i[i]` (index 0 to 4 in the order of R3) sets error flag i only while control enable bit i is 1. Enable bit i is written through `ctl_wdata[i]` with `ctl_we`. An event whose enable is 0 leaves the flag unchanged.
- R7: An enabled hardware event in the same cycle as a clear of that flag wins, and the flag ends up set.
- R8: Error flags are sticky: they stay set after the event goes low, until they are cleared by a command.
- R9: `err_irq_o` is high exactly when some error flag whose control enable is 1 is set and interrupt-enable bit 2 is 1.
- R10: `status_o[13]` follows `busy_i` in the same cycle. `cfg_mode_o` is the inverse of the enable flag.
- R11: The mode-error flag shows at `status_o[15]`. It is cleared by command bit 6 and set by command bit 7, and `mode_ev_i` sets it with no enable gate.
- R12: The interrupt-enable register is loaded from `ien_wdata` when `ien_we` is high and is read on `ien_o`, with receive = bit 0, transmit = bit 1, error = bit 2 and frame end = bit 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 16 | Command word with set/clear bit pairs |
| ctl_we | input | 1 | Error-enable write strobe |
| ctl_wdata | input | 5 | Per-error enable bits |
| ien_we | input | 1 | Interrupt-enable write strobe |
| ien_wdata | input | 4 | Interrupt-enable value |
| err_ev_i | input | 5 | Hardware error events |
| mode_ev_i | input | 1 | Hardware mode-error event |
| busy_i | input | 1 | Shift engine busy |
| status_o | output | 16 | State word |
| ien_o | output | 4 | Interrupt-enable register |
| err_irq_o | output | 1 | Error interrupt |
| cfg_mode_o | output | 1 | High while in configuration mode |

## Verification
A clear command and an enabled hardware event can hit the same error flag in the same cycle. The bench drives a clear of the transmit-overflow flag while its event is high and expects the flag to stay set. It also writes a set bit together with its clear bit and expects no change. A scoreboard model built from the requirements predicts every state word, and a monitor compares each prediction with the ports a quarter period after the clock edge.

// File: rtl/err_status_reg.sv
module err_status_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [15:0] cmd_wdata,
  input  logic        ctl_we,
  input  logic [4:0]  ctl_wdata,
  input  logic        ien_we,
  input  logic [3:0]  ien_wdata,
  input  logic [4:0]  err_ev_i,
  input  logic        mode_ev_i,
  input  logic        busy_i,
  output logic [15:0] status_o,
  output logic [3:0]  ien_o,
  output logic        err_irq_o,
  output logic        cfg_mode_o
);
  localparam int NERR = 5;

  logic            en_q, ms_q, me_q;
  logic [NERR-1:0] err_q, een_q;
  logic [3:0]      ien_q;

  function automatic logic upd(logic q, logic s, logic c, logic ev);
    if (ev)          return 1'b1;
    if (s && !c)     return 1'b1;
    if (c && !s)     return 1'b0;
    return q;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      ms_q <= 1'b0;
      me_q <= 1'b0;
    end else begin
      en_q <= upd(en_q, cmd_we & cmd_wdata[1], cmd_we & cmd_wdata[0], 1'b0);
      ms_q <= upd(ms_q, cmd_we & cmd_wdata[3], cmd_we & cmd_wdata[2], 1'b0);
      me_q <= upd(me_q, cmd_we & cmd_wdata[7], cmd_we & cmd_wdata[6], mode_ev_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      een_q <= '0;
      ien_q <= '0;
    end else begin
      if (ctl_we) een_q <= ctl_wdata;
      if (ien_we) ien_q <= ien_wdata;
    end
  end

  for (genvar i = 0; i < NERR; i++) begin : g_err
    localparam int CP = (i == 4) ? 4 : 8 + i;
    localparam int SP = (i == 4) ? 5 : 12 + i;
    logic s, c, e;
    assign s = cmd_we & cmd_wdata[SP];
    assign c = cmd_we & cmd_wdata[CP];
    assign e = err_ev_i[i] & een_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q[i] <= 1'b0;
      else        err_q[i] <= upd(err_q[i], s, c, e);
    end

    // R8: a flag not explicitly cleared stays set
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q[i] && !(cmd_we && cmd_wdata[CP] && !cmd_wdata[SP])) |=> err_q[i]);
    // R6, R7: an enabled event always lands, even against a clear
    assert_event_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (err_ev_i[i] && een_q[i]) |=> err_q[i]);
    // R6: a disabled event never sets a clear flag on its own
    assert_gated_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!err_q[i] && !een_q[i] && !(cmd_we && cmd_wdata[SP])) |=> !err_q[i]);
    // R4: set together with clear holds the flag
    assert_both_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && cmd_wdata[SP] && cmd_wdata[CP] && !err_ev_i[i]) |=> $stable(err_q[i]));
  end

  assign status_o   = {me_q, 1'b0, busy_i, err_q, 6'b0, ms_q, en_q};
  assign ien_o      = ien_q;
  assign err_irq_o  = ien_q[2] & |(err_q & een_q);
  assign cfg_mode_o = ~en_q;

  // R9: interrupt masked while the error request enable is off
  assert_irq_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ien_q[2] |-> !err_irq_o);
  // R2: a lone clear of the enable bit returns to configuration mode
  assert_clr_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_wdata[0] && !cmd_wdata[1]) |=> cfg_mode_o);
  // R11: mode event always sets the mode-error flag
  assert_mode_ev_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ev_i |=> status_o[15]);
endmodule

// File: tb/test_err_status_reg.sv
module test_err_status_reg;
  localparam time CLK = 10ns;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_we = 0, ctl_we = 0, ien_we = 0, mode_ev_i = 0, busy_i = 0;
  logic [15:0] cmd_wdata = '0;
  logic [4:0]  ctl_wdata = '0, err_ev_i = '0;
  logic [3:0]  ien_wdata = '0;
  logic [15:0] status_o;
  logic [3:0]  ien_o;
  logic        err_irq_o, cfg_mode_o;

  err_status_reg i_err_status_reg (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ien_we(ien_we), .ien_wdata(ien_wdata),
    .err_ev_i(err_ev_i), .mode_ev_i(mode_ev_i), .busy_i(busy_i),
    .status_o(status_o), .ien_o(ien_o), .err_irq_o(err_irq_o), .cfg_mode_o(cfg_mode_o));

  always #(CLK/2) clk = ~clk;

  typedef struct { logic [15:0] st; logic [3:0] ien; logic irq; logic cfg; string tag; } exp_t;
  exp_t q[$];
  int   n_run = 0, n_fail = 0;

  logic       m_en = 0, m_ms = 0, m_me = 0;
  logic [4:0] m_err = '0, m_een = '0;
  logic [3:0] m_ien = '0;

  function automatic logic nxt(logic v, logic s, logic c, logic e);
    return e ? 1'b1 : (s && !c) ? 1'b1 : (c && !s) ? 1'b0 : v;
  endfunction

  task automatic check(exp_t x);
    n_run++;
    if (status_o !== x.st || ien_o !== x.ien || err_irq_o !== x.irq || cfg_mode_o !== x.cfg) begin
      n_fail++;
      $display("FAIL %s: actual st=%h ien=%h irq=%b cfg=%b expected st=%h ien=%h irq=%b cfg=%b",
               x.tag, status_o, ien_o, err_irq_o, cfg_mode_o, x.st, x.ien, x.irq, x.cfg);
    end
  endtask

  task automatic drive(input logic cwe, input logic [15:0] cw, input logic twe, input logic [4:0] tw,
                       input logic iwe, input logic [3:0] iw, input logic [4:0] ev,
                       input logic evm, input logic bsy, input string tag);
    exp_t x;
    cmd_we = cwe; cmd_wdata = cw; ctl_we = twe; ctl_wdata = tw;
    ien_we = iwe; ien_wdata = iw; err_ev_i = ev; mode_ev_i = evm; busy_i = bsy;
    for (int i = 0; i < 5; i++) begin
      int cp = (i == 4) ? 4 : 8 + i;
      int sp = (i == 4) ? 5 : 12 + i;
      m_err[i] = nxt(m_err[i], cwe & cw[sp], cwe & cw[cp], ev[i] & m_een[i]);
    end
    m_en = nxt(m_en, cwe & cw[1], cwe & cw[0], 1'b0);
    m_ms = nxt(m_ms, cwe & cw[3], cwe & cw[2], 1'b0);
    m_me = nxt(m_me, cwe & cw[7], cwe & cw[6], evm);
    if (twe) m_een = tw;
    if (iwe) m_ien = iw;
    x.st  = {m_me, 1'b0, bsy, m_err, 6'b0, m_ms, m_en};
    x.ien = m_ien;
    x.irq = m_ien[2] & |(m_err & m_een);
    x.cfg = ~m_en;
    x.tag = tag;
    @(posedge clk);
    q.push_back(x);
    @(negedge clk);
    cmd_we = 0; ctl_we = 0; ien_we = 0; err_ev_i = '0; mode_ev_i = 0;
  endtask

  task automatic cmd(input logic [15:0] cw, input string tag);
    drive(1, cw, 0, '0, 0, '0, '0, 0, busy_i, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #(CLK/4);
      while (q.size() > 0) check(q.pop_front());
    end
  end

  initial begin
    #(CLK * 5000);
    n_fail++;
    $display("FAIL watchdog R1..: actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    exp_t r;
    #(CLK * 2);
    r.st = 16'h0000; r.ien = 4'h0; r.irq = 0; r.cfg = 1; r.tag = "R1 reset";
    check(r);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    cmd(16'h0002, "R2 set enable / R10 run mode");
    cmd(16'h0008, "R2 set master");
    cmd(16'h0004, "R2 clear master");
    cmd(16'h0008, "R2 set master again");
    cmd(16'hF020, "R3 set all error flags");
    cmd(16'h0010, "R3 clear rx underflow bit 4");
    cmd(16'h0400, "R3 clear abort bit 10");
    cmd(16'h0080, "R11 set mode error bit 7");
    cmd(16'h0F50, "R5 clear all errors");
    cmd(16'h0003, "R4 set+clear enable holds");
    cmd(16'h1100, "R4 set+clear tx overflow holds");
    drive(0, '0, 0, '0, 0, '0, 5'h1F, 0, 0, "R6 events ignored when disabled");
    drive(0, '0, 1, 5'b00101, 1, 4'b0100, '0, 0, 0, "R12 write enables");
    drive(0, '0, 0, '0, 0, '0, 5'h1F, 0, 0, "R6 enabled events set / R9 irq");
    drive(0, '0, 0, '0, 0, '0, '0, 0, 0, "R8 flags sticky");
    drive(1, 16'h0100, 0, '0, 0, '0, 5'h01, 0, 0, "R7 event beats clear");
    cmd(16'h0500, "R9 clear enabled flags, irq drops");
    cmd(16'h2000, "R9 flag with enable off gives no irq");
    drive(0, '0, 0, '0, 1, 4'b1011, '0, 0, 0, "R12 ien readback / R9 mask");
    drive(0, '0, 0, '0, 0, '0, '0, 0, 1, "R10 busy shown");
    drive(0, '0, 0, '0, 0, '0, '0, 1, 1, "R11 mode event sets");
    cmd(16'h0040, "R11 clear mode error bit 6");
    cmd(16'h0001, "R2 clear enable / R10 config mode");
    cmd(16'h0F50, "R5 keeps master");
    @(negedge clk); @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule